// File: doc/BRIEF.md
# Flash Operation Status Readout

This block sits on the read path of a NOR-style flash array model. While an embedded program or erase operation is running, it substitutes status bits for the array data on the 8-bit read bus. When no operation is running, it passes array data through unchanged. The surrounding model supplies the following inputs:

- a strobe marking the final write-enable edge of a command sequence, together with the operation kind;
- completion and timeout strobes from the sequencer;
- a flag reporting that every selected sector is protected;
- a reset command;
- the latched program datum and its address;
- the read address, the chip and output enables, and the array word.

Each kind of operation has its own status encoding:

- Bit 7 is the polling bit. During a program it reads the inverse of the datum's bit 7 at the program address. During an erase it reads 0.
- Bit 6 inverts after every completed read cycle.
- Bit 5 flags an operation that exceeded its internal limit. That failure state holds status on the bus until a reset command.
- An erase aimed only at protected sectors shows erase polling for a hold window of about 100 µs. The window length is derived from the clock frequency. After it closes, the bus returns to array reads.

Programs issued while an erase is suspended use the same program polling.

Top module: `flash_status_readout`

## Requirements
- R1: After reset, no operation is active. A read (ce_n=0 and oe_n=0) returns array_data, and dq is 0 whenever no read is in progress.
- R2: While a program runs, a read at rd_addr==prog_addr returns bit 7 = NOT prog_data[7]. A read at any other address returns bit 7 = 0.
- R3: After alg_done ends a program, reads return array_data again, so the programmed datum reads back true.
- R4: While an erase runs, bit 7 of every read is 0. After alg_done, reads return array_data.
- R5: Status starts in the clock cycle after the cycle in which alg_start is high. Before that, reads return array_data.
- R6: While status is shown, bit 6 inverts after every completed read cycle, whether the cycle is delimited by oe_n or by ce_n. Once the operation ends, successive reads return identical array data.
- R7: An alg_timeout during an operation sets bit 5 to 1. Polling on bit 7 and toggling on bit 6 continue. A later alg_done has no effect, and status stays on the bus until reset_cmd.
- R8: An alg_start with alg_erase=1 and sect_all_prot=1 shows erase status (bit 7 = 0) for CLK_HZ/1e6*HOLD_US cycles, then reads return array_data.
- R9: reset_cmd returns the block to array reads from any state and clears bit 5.
- R10: While status is shown, bits 4:0 read 0, and bit 5 reads 0 unless the operation failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alg_start | input | 1 | Final write-enable edge of a program/erase sequence |
| alg_erase | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| alg_done | input | 1 | Sequencer reports successful completion |
| alg_timeout | input | 1 | Sequencer reports pulse-count limit exceeded |
| sect_all_prot | input | 1 | Every sector selected for erase is protected |
| reset_cmd | input | 1 | Reset command decoded |
| prog_addr | input | ADDR_W | Latched program address |
| prog_data | input | 8 | Latched program datum |
| rd_addr | input | ADDR_W | Read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | 8 | Array word at rd_addr |
| dq | output | 8 | Read data bus |

## Verification
The tests cover several operation types:

- Programs with prog_data bit 7 at 1 and at 0, read at and away from the program address. This separates inverted polling from a constant or an address-blind response.
- Erases with and without fully protected sectors, read both inside and beyond the hold window. This tells the sequencer-bounded end from the timer-bounded end.
- Pairs of back-to-back reads driven by oe_n and by ce_n, both during status and when idle. These show that bit 6 alternates only while status is up.
- A timeout followed by a stray completion strobe and then a reset command. This shows that the failure state is sticky and is cleared only by the reset command.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int DQ_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_PROT  = 3'd3,
    ST_FAIL  = 3'd4
  } fsr_state_t;
endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fsr_hold_timer.sv
module fsr_hold_timer #(
  parameter int HOLD_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!expire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: the window counter never passes its terminal count
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8: an idle timer sits at zero on the following cycle
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_act,
  input  logic stat_act,
  output logic tog
);
  logic rd_q;
  logic tog_q, tog_d;
  logic rd_end;

  assign rd_end = rd_q && !rd_act;

  always_comb begin
    tog_d = tog_q;
    if (rd_end && stat_act) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q  <= rd_act;
      tog_q <= tog_d;
    end
  end

  assign tog = tog_q;

  // R6: bit 6 holds still for the whole duration of one read cycle
  a_r6_stable_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && rd_act) |=> $stable(tog_q));
endmodule

// File: rtl/fsr_seq_fsm.sv
module fsr_seq_fsm
  import flash_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alg_start,
  input  logic       alg_erase,
  input  logic       alg_done,
  input  logic       alg_timeout,
  input  logic       sect_all_prot,
  input  logic       reset_cmd,
  input  logic       hold_expire,
  output fsr_state_t state,
  output logic       erase_kind,
  output logic       hold_run
);
  fsr_state_t st_q, st_d;
  logic       kind_q, kind_d;
  logic       kind_en;

  assign kind_en = (st_q == ST_IDLE) && alg_start && !reset_cmd;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (kind_en) begin
          if (alg_erase && sect_all_prot) st_d = ST_PROT;
          else if (alg_erase)             st_d = ST_ERASE;
          else                            st_d = ST_PROG;
        end
      end
      ST_PROG, ST_ERASE: begin
        if (reset_cmd)        st_d = ST_IDLE;
        else if (alg_timeout) st_d = ST_FAIL;
        else if (alg_done)    st_d = ST_IDLE;
      end
      ST_PROT: begin
        if (reset_cmd || hold_expire) st_d = ST_IDLE;
      end
      ST_FAIL: begin
        if (reset_cmd) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    kind_d = kind_q;
    if (kind_en) kind_d = alg_erase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
    end
  end

  assign state      = st_q;
  assign erase_kind = kind_q;
  assign hold_run   = (st_q == ST_PROT);

  // R9: a reset command always lands in the idle state
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> st_q == ST_IDLE);
  // R7: failure persists until a reset command
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL && !reset_cmd) |=> st_q == ST_FAIL);
  // R8: the protected-erase hold ends only by timer or reset
  a_r8_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROT && !hold_expire && !reset_cmd) |=> st_q == ST_PROT);
  // R5: an operation begins the cycle after the start strobe
  a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && alg_start && !reset_cmd) |=> st_q != ST_IDLE);
endmodule

// File: rtl/flash_status_readout.sv
module flash_status_readout
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int CLK_HZ  = 50_000_000,
  parameter int HOLD_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alg_start,
  input  logic              alg_erase,
  input  logic              alg_done,
  input  logic              alg_timeout,
  input  logic              sect_all_prot,
  input  logic              reset_cmd,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [7:0]        array_data,
  output logic [7:0]        dq
);
  localparam int HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;

  logic       rst_n_s;
  fsr_state_t state;
  logic       erase_kind;
  logic       hold_run;
  logic       hold_expire;
  logic       tog;
  logic       rd_act;
  logic       stat_act;
  logic       failed;
  logic       poll_bit;
  logic [DQ_W-1:0] stat_word;

  fsr_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  fsr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (hold_run),
    .expire(hold_expire)
  );

  fsr_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .alg_start    (alg_start),
    .alg_erase    (alg_erase),
    .alg_done     (alg_done),
    .alg_timeout  (alg_timeout),
    .sect_all_prot(sect_all_prot),
    .reset_cmd    (reset_cmd),
    .hold_expire  (hold_expire),
    .state        (state),
    .erase_kind   (erase_kind),
    .hold_run     (hold_run)
  );

  assign rd_act   = !ce_n && !oe_n;
  assign stat_act = (state != ST_IDLE);
  assign failed   = (state == ST_FAIL);

  fsr_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_act  (rd_act),
    .stat_act(stat_act),
    .tog     (tog)
  );

  always_comb begin
    poll_bit = 1'b0;
    if (!erase_kind && (rd_addr == prog_addr)) poll_bit = ~prog_data[7];
  end

  assign stat_word = {poll_bit, tog, failed, 5'b00000};

  always_comb begin
    dq = '0;
    if (rd_act) dq = stat_act ? stat_word : array_data;
  end

  // R1: the bus is quiet outside read cycles
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_act |-> dq == 8'h00);
  // R10: spare status bits read 0
  a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_act && stat_act) |-> dq[4:0] == 5'b00000);
  // R4: erase polling reads 0 on bit 7
  a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_act && state == ST_ERASE) |-> !dq[7]);
  // R10: bit 5 only under failure
  a_r10_fail_only: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_act && stat_act && state != ST_FAIL) |-> !dq[5]);
endmodule

// File: tb/flash_status_readout_tb.sv
module flash_status_readout_tb;
  localparam int ADDR_W = 22;
  localparam int HOLD   = 50 * 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alg_start = 0, alg_erase = 0, alg_done = 0, alg_timeout = 0;
  logic sect_all_prot = 0, reset_cmd = 0;
  logic [ADDR_W-1:0] prog_addr = '0, rd_addr = '0;
  logic [7:0] prog_data = '0, array_data = '0;
  logic ce_n = 1, oe_n = 1;
  logic [7:0] dq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_status_readout #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .alg_start(alg_start), .alg_erase(alg_erase),
    .alg_done(alg_done), .alg_timeout(alg_timeout),
    .sect_all_prot(sect_all_prot), .reset_cmd(reset_cmd),
    .prog_addr(prog_addr), .prog_data(prog_data), .rd_addr(rd_addr),
    .ce_n(ce_n), .oe_n(oe_n), .array_data(array_data), .dq(dq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input bit via_ce, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    if (via_ce) begin oe_n = 0; ce_n = 0; end
    else        begin ce_n = 0; oe_n = 0; end
    @(posedge clk); #2;
    d = dq;
    @(negedge clk);
    if (via_ce) ce_n = 1; else oe_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic er, input logic prot);
    @(negedge clk);
    alg_start = 1; alg_erase = er; sect_all_prot = prot;
    @(negedge clk);
    alg_start = 0; sect_all_prot = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #3 chk("R1 idle bus", dq, 8'h00);
    array_data = 8'h5A;
    rd(22'h10, 0, d);
    chk("R1 array read", d, 8'h5A);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic t_program();
    logic [7:0] d, d2;
    prog_addr = 22'h123; prog_data = 8'hA5; array_data = 8'h3C;
    rd(22'h123, 0, d);
    chk("R5 before start", d, 8'h3C);
    pulse_start(0, 0);
    rd(22'h123, 0, d);
    chk("R2/R10 poll inverted (bit6 masked)", d & 8'hBF, 8'h00);
    chk("R5 status on after start", {7'd0, d === 8'h3C}, 8'h00);
    rd(22'h124, 0, d);
    chk("R2 other address bit7", {7'd0, d[7]}, 8'h00);
    prog_data = 8'h21;
    rd(22'h123, 0, d);
    rd(22'h123, 0, d2);
    chk("R2 poll inverted of 0", d2 & 8'hBF, 8'h80);
    chk("R6 oe toggle", {7'd0, d[6] ^ d2[6]}, 8'h01);
    rd(22'h123, 1, d);
    chk("R6 ce toggle", {7'd0, d[6] ^ d2[6]}, 8'h01);
    rd(22'h123, 1, d2);
    chk("R6 ce toggle again", {7'd0, d[6] ^ d2[6]}, 8'h01);
    pulse(alg_done);
    array_data = 8'h21;
    rd(22'h123, 0, d);
    chk("R3 true datum", d, 8'h21);
    rd(22'h123, 0, d2);
    chk("R6 idle no toggle", d2, d);
    oe_n = 1; ce_n = 1;
  endtask

  task automatic t_erase();
    logic [7:0] d;
    array_data = 8'h00;
    pulse_start(1, 0);
    rd(22'h123, 0, d);
    chk("R4 erase poll", d & 8'hBF, 8'h00);
    rd(22'h3FF, 1, d);
    chk("R4 erase poll any addr", d & 8'hBF, 8'h00);
    pulse(alg_done);
    array_data = 8'hFF;
    rd(22'h3FF, 0, d);
    chk("R4 erased reads", d, 8'hFF);
    oe_n = 1; ce_n = 1;
  endtask

  task automatic t_timeout();
    logic [7:0] d, d2;
    prog_data = 8'h80; prog_addr = 22'h40; array_data = 8'h11;
    pulse_start(0, 0);
    pulse(alg_timeout);
    rd(22'h40, 0, d);
    chk("R7 fail bit", d & 8'hBF, 8'h20);
    pulse(alg_done);
    rd(22'h40, 0, d2);
    chk("R7 done ignored", d2 & 8'hBF, 8'h20);
    chk("R7 toggle in fail", {7'd0, d[6] ^ d2[6]}, 8'h01);
    pulse(reset_cmd);
    rd(22'h40, 0, d);
    chk("R9 reset clears fail", d, 8'h11);
    oe_n = 1; ce_n = 1;
  endtask

  task automatic t_prot();
    logic [7:0] d;
    array_data = 8'h77;
    pulse_start(1, 1);
    rd(22'h5, 0, d);
    chk("R8 hold status early", d & 8'hBF, 8'h00);
    repeat (HOLD - 40) @(negedge clk);
    rd(22'h5, 0, d);
    chk("R8 hold status late", d & 8'hBF, 8'h00);
    repeat (80) @(negedge clk);
    rd(22'h5, 0, d);
    chk("R8 array after window", d, 8'h77);
    oe_n = 1; ce_n = 1;
  endtask

  task automatic t_reset_cmd();
    logic [7:0] d;
    array_data = 8'h9C;
    pulse_start(1, 0);
    pulse(reset_cmd);
    rd(22'h5, 0, d);
    chk("R9 reset from erase", d, 8'h9C);
    pulse_start(1, 1);
    pulse(reset_cmd);
    rd(22'h5, 0, d);
    chk("R9 reset from hold", d, 8'h9C);
    oe_n = 1; ce_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_timeout();
    t_prot();
    t_reset_cmd();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule